// File: doc/BRIEF.md
# Polarity-Selectable Phase/Frequency Detector

This block compares the rising edges of a reference clock (`ref_in`) with the rising edges of a divided feedback clock (`fb_in`). Both signals are sampled in the system clock domain. A rising reference edge sets an UP flag and a rising feedback edge sets a DOWN flag. Once both flags are set, they stay set together for a short fixed window and then clear together. That window is what gives the minimum overlap pulse that keeps a charge pump out of its dead band. Because a flag stays set until the other input catches up, the comparison spans a full ±2π.

A single select input, `pol_sel`, does two jobs. It chooses which sense the comparator and the pump drive use, and it chooses which of the two compared signals is copied to the monitor output. The detector also drives:
- two logic-level steering outputs,
- source/sink enables for a main pump (both low means high impedance),
- an auxiliary copy of the pump enables, which is only active while `sw_en` is high,
- an active-low lock indicator that is the NOR of the two flags.

Top module: `polsel_pfd`

## Requirements
- R1: While `rst` is high and on the first edge after it, `up_flag`, `dn_flag`, `ph_r_out` and all four pump enables are 0, and `ph_p_out` and `lock_n` are 1.
- R2: A low-to-high level on `ref_in` that is first sampled at clock edge k sets `up_flag` at edge k+2. The steering, pump and lock outputs follow at edge k+3. The same timing applies to `fb_in` and `dn_flag`.
- R3: A set flag stays set until the other flag is also set. Further rising edges on the input that set it have no effect. If the first rising edges of the two inputs are D cycles apart, the leading flag is high for D+RST_DLY cycles.
- R4: When both flags are set, both stay high for exactly RST_DLY cycles (default 2) and then clear on the same edge. When both inputs rise together, each flag is high for RST_DLY cycles.
- R5: With `pol_sel`=1: `ph_r_out` = DOWN, `ph_p_out` = NOT UP, `main_src_en` = UP, and `main_snk_en` = DOWN. Each output uses the flag values from the previous cycle.
- R6: With `pol_sel`=0, the roles swap: `ph_r_out` = UP, `ph_p_out` = NOT DOWN, `main_src_en` = DOWN, and `main_snk_en` = UP.
- R7: `lock_n` is the NOR of the previous cycle's UP and DOWN flags. It is 1 when idle and 0 for every cycle in which either flag was set.
- R8: While `sw_en`=1, `aux_src_en`/`aux_snk_en` equal `main_src_en`/`main_snk_en`. While `sw_en`=0, both auxiliary enables are 0 (high impedance).
- R9: `mon_out` carries the synchronized `ref_in` level when `pol_sel`=1 and the synchronized `fb_in` level when `pol_sel`=0. It changes one edge after `pol_sel` changes, and two edges after the first sampling edge of an input level.
- R10: Falling edges on `ref_in` and `fb_in` set no flag. `lock_n` stays 1 across them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock to compare |
| fb_in | input | 1 | Divided feedback clock to compare |
| pol_sel | input | 1 | 1: normal sense and monitor shows reference; 0: reversed sense and monitor shows feedback |
| sw_en | input | 1 | Enables the auxiliary pump enables |
| up_flag | output | 1 | UP state flag (reference edge seen first) |
| dn_flag | output | 1 | DOWN state flag (feedback edge seen first) |
| ph_r_out | output | 1 | Steering output, high pulses request a lower frequency |
| ph_p_out | output | 1 | Steering output, low pulses request a higher frequency |
| main_src_en | output | 1 | Main pump source enable |
| main_snk_en | output | 1 | Main pump sink enable |
| aux_src_en | output | 1 | Auxiliary pump source enable |
| aux_snk_en | output | 1 | Auxiliary pump sink enable |
| lock_n | output | 1 | Active-low phase/frequency error indicator |
| mon_out | output | 1 | Monitor copy of reference or feedback |

## Verification
A rising input level first sampled at edge k reaches its flag at edge k+2 and the registered outputs at edge k+3. The bench drives every input on a falling clock edge and checks this exact latency once. It then counts how many cycles each output spends in its active level over a window long enough to hold the whole pulse, so the sweep checks pulse widths (D+RST_DLY and RST_DLY) independently of the pipeline offset. The monitor output is sampled exactly two edges after an input change and one edge after a `pol_sel` change.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  localparam int NUM_CH = 2;
  localparam int CH_REF = 0;
  localparam int CH_FB  = 1;

  typedef struct packed {
    logic src;
    logic snk;
  } pump_en_t;

  typedef struct packed {
    logic ph_r;
    logic ph_p;
  } steer_t;

  function automatic pump_en_t pump_map(input logic pol, input logic up, input logic dn);
    pump_en_t p;
    p.src = pol ? up : dn;
    p.snk = pol ? dn : up;
    return p;
  endfunction

  function automatic steer_t steer_map(input logic pol, input logic up, input logic dn);
    steer_t s;
    s.ph_r = pol ? dn : up;
    s.ph_p = pol ? ~up : ~dn;
    return s;
  endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);

  localparam int DEPTH = STAGES + 1;

  logic [DEPTH-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else begin
      shreg <= {shreg[DEPTH-2:0], din};
    end
  end

  assign level = shreg[STAGES-1];
  assign rise  = shreg[STAGES-1] & ~shreg[STAGES];

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);  // R2

endmodule

// File: rtl/pfd_flag_fsm.sv
module pfd_flag_fsm #(
  parameter int RST_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rise_ref,
  input  logic rise_fb,
  output logic up_q,
  output logic dn_q
);

  localparam int CW = (RST_DLY < 2) ? 1 : $clog2(RST_DLY + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_DLY - 1);

  logic [CW-1:0] win_cnt;
  logic          both;

  assign both = up_q & dn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      win_cnt <= '0;
    end else if (both) begin
      if (win_cnt == LAST) begin
        up_q    <= 1'b0;
        dn_q    <= 1'b0;
        win_cnt <= '0;
      end else begin
        win_cnt <= win_cnt + 1'b1;
      end
    end else begin
      if (rise_ref) up_q <= 1'b1;
      if (rise_fb)  dn_q <= 1'b1;
    end
  end

  AST_UP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (up_q && !dn_q) |=> up_q);  // R3
  AST_DN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (dn_q && !up_q) |=> dn_q);  // R3
  AST_CLEAR_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $fell(up_q) |-> $fell(dn_q));  // R4

endmodule

// File: rtl/pfd_out_map.sv
module pfd_out_map
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pol_sel,
  input  logic sw_en,
  input  logic up_q,
  input  logic dn_q,
  input  logic ref_lvl,
  input  logic fb_lvl,
  output logic ph_r_out,
  output logic ph_p_out,
  output logic main_src_en,
  output logic main_snk_en,
  output logic aux_src_en,
  output logic aux_snk_en,
  output logic lock_n,
  output logic mon_out
);

  pump_en_t main_d;
  pump_en_t aux_d;
  steer_t   steer_d;

  always_comb begin
    main_d  = pump_map(pol_sel, up_q, dn_q);
    steer_d = steer_map(pol_sel, up_q, dn_q);
    aux_d   = sw_en ? main_d : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_r_out    <= 1'b0;
      ph_p_out    <= 1'b1;
      main_src_en <= 1'b0;
      main_snk_en <= 1'b0;
      aux_src_en  <= 1'b0;
      aux_snk_en  <= 1'b0;
      lock_n      <= 1'b1;
      mon_out     <= 1'b0;
    end else begin
      ph_r_out    <= steer_d.ph_r;
      ph_p_out    <= steer_d.ph_p;
      main_src_en <= main_d.src;
      main_snk_en <= main_d.snk;
      aux_src_en  <= aux_d.src;
      aux_snk_en  <= aux_d.snk;
      lock_n      <= ~(up_q | dn_q);
      mon_out     <= pol_sel ? ref_lvl : fb_lvl;
    end
  end

  AST_LOCK_LOW: assert property (@(posedge clk) disable iff (rst)
    (up_q || dn_q) |=> !lock_n);  // R7
  AST_LOCK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!up_q && !dn_q) |=> lock_n);  // R7
  AST_AUX_OFF: assert property (@(posedge clk) disable iff (rst)
    !sw_en |=> (!aux_src_en && !aux_snk_en));  // R8
  AST_MON_REF: assert property (@(posedge clk) disable iff (rst)
    pol_sel |=> (mon_out == $past(ref_lvl)));  // R9
  AST_SRC_UP_POS: assert property (@(posedge clk) disable iff (rst)
    (pol_sel && up_q) |=> main_src_en);  // R5
  AST_SRC_DN_NEG: assert property (@(posedge clk) disable iff (rst)
    (!pol_sel && dn_q) |=> main_src_en);  // R6

endmodule

// File: rtl/polsel_pfd.sv
module polsel_pfd
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_DLY     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  input  logic pol_sel,
  input  logic sw_en,
  output logic up_flag,
  output logic dn_flag,
  output logic ph_r_out,
  output logic ph_p_out,
  output logic main_src_en,
  output logic main_snk_en,
  output logic aux_src_en,
  output logic aux_snk_en,
  output logic lock_n,
  output logic mon_out
);

  logic [NUM_CH-1:0] ch_in;
  logic [NUM_CH-1:0] ch_lvl;
  logic [NUM_CH-1:0] ch_rise;

  assign ch_in[CH_REF] = ref_in;
  assign ch_in[CH_FB]  = fb_in;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_sync
    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .din   (ch_in[g]),
      .level (ch_lvl[g]),
      .rise  (ch_rise[g])
    );
  end

  pfd_flag_fsm #(.RST_DLY(RST_DLY)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .rise_ref (ch_rise[CH_REF]),
    .rise_fb  (ch_rise[CH_FB]),
    .up_q     (up_flag),
    .dn_q     (dn_flag)
  );

  pfd_out_map u_map (
    .clk         (clk),
    .rst         (rst),
    .pol_sel     (pol_sel),
    .sw_en       (sw_en),
    .up_q        (up_flag),
    .dn_q        (dn_flag),
    .ref_lvl     (ch_lvl[CH_REF]),
    .fb_lvl      (ch_lvl[CH_FB]),
    .ph_r_out    (ph_r_out),
    .ph_p_out    (ph_p_out),
    .main_src_en (main_src_en),
    .main_snk_en (main_snk_en),
    .aux_src_en  (aux_src_en),
    .aux_snk_en  (aux_snk_en),
    .lock_n      (lock_n),
    .mon_out     (mon_out)
  );

  AST_AUX_MIRROR: assert property (@(posedge clk) disable iff (rst)
    $past(sw_en) |-> (aux_src_en == main_src_en && aux_snk_en == main_snk_en));  // R8

endmodule

// File: tb/tb_polsel_pfd.sv
`timescale 1ns/1ps
module tb_polsel_pfd;

  localparam int SYNC = 2;
  localparam int RD   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, fb_in = 1'b0, pol_sel = 1'b1, sw_en = 1'b1;
  logic up_flag, dn_flag, ph_r_out, ph_p_out;
  logic main_src_en, main_snk_en, aux_src_en, aux_snk_en, lock_n, mon_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  polsel_pfd #(.SYNC_STAGES(SYNC), .RST_DLY(RD)) dut (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .pol_sel(pol_sel),
    .sw_en(sw_en), .up_flag(up_flag), .dn_flag(dn_flag), .ph_r_out(ph_r_out),
    .ph_p_out(ph_p_out), .main_src_en(main_src_en), .main_snk_en(main_snk_en),
    .aux_src_en(aux_src_en), .aux_snk_en(aux_snk_en), .lock_n(lock_n),
    .mon_out(mon_out)
  );

  bit cnt_en = 0;
  int c_up, c_dn, c_lockl, c_rhi, c_plo, c_src, c_snk, c_asrc, c_asnk;

  always @(negedge clk) begin
    if (cnt_en) begin
      c_up    += int'(up_flag);
      c_dn    += int'(dn_flag);
      c_lockl += int'(!lock_n);
      c_rhi   += int'(ph_r_out);
      c_plo   += int'(!ph_p_out);
      c_src   += int'(main_src_en);
      c_snk   += int'(main_snk_en);
      c_asrc  += int'(aux_src_en);
      c_asnk  += int'(aux_snk_en);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_cnt();
    c_up = 0; c_dn = 0; c_lockl = 0; c_rhi = 0; c_plo = 0;
    c_src = 0; c_snk = 0; c_asrc = 0; c_asnk = 0;
  endtask

  // Checks every counted output against the two flag widths.
  task automatic check_counts(input string ctx, input int fc, input int le,
                              input int exp_up, input int exp_dn, input int exp_any);
    string pt;
    pt = fc ? "R5" : "R6";
    chk({ctx, " R3/up"}, c_up, exp_up);
    chk({ctx, " R4/dn"}, c_dn, exp_dn);
    chk({ctx, " R7 lock low"}, c_lockl, exp_any);
    chk({ctx, " ", pt, " ph_r high"}, c_rhi, fc ? exp_dn : exp_up);
    chk({ctx, " ", pt, " ph_p low"}, c_plo, fc ? exp_up : exp_dn);
    chk({ctx, " ", pt, " src"}, c_src, fc ? exp_up : exp_dn);
    chk({ctx, " ", pt, " snk"}, c_snk, fc ? exp_dn : exp_up);
    chk({ctx, " R8 aux src"}, c_asrc, le ? (fc ? exp_up : exp_dn) : 0);
    chk({ctx, " R8 aux snk"}, c_asnk, le ? (fc ? exp_dn : exp_up) : 0);
  endtask

  task automatic trial(input int ref_first, input int d, input int fc, input int le);
    pol_sel = fc[0]; sw_en = le[0];
    tick(4);
    clr_cnt(); cnt_en = 1;
    if (d == 0) begin
      ref_in = 1; fb_in = 1;
    end else begin
      if (ref_first != 0) ref_in = 1; else fb_in = 1;
      tick(d);
      if (ref_first != 0) fb_in = 1; else ref_in = 1;
    end
    tick(12 + RD);
    ref_in = 0; fb_in = 0;
    tick(6);
    cnt_en = 0;
    if (ref_first != 0)
      check_counts($sformatf("sweep fc=%0d le=%0d ref_first d=%0d", fc, le, d), fc, le, d + RD, RD, d + RD);
    else
      check_counts($sformatf("sweep fc=%0d le=%0d fb_first d=%0d", fc, le, d), fc, le, RD, d + RD, d + RD);
  endtask

  initial begin
    tick(3);
    // R1: reset values held while reset is asserted
    chk("R1 up", up_flag, 0); chk("R1 dn", dn_flag, 0);
    chk("R1 ph_r", ph_r_out, 0); chk("R1 ph_p", ph_p_out, 1);
    chk("R1 lock_n", lock_n, 1);
    chk("R1 pumps", {main_src_en, main_snk_en, aux_src_en, aux_snk_en}, 0);
    rst = 0;
    tick(1);
    chk("R1 lock_n after release", lock_n, 1);

    // R2: latency of a reference edge, pol_sel=1
    ref_in = 1;
    tick(2); chk("R2 up not yet at k+1", up_flag, 0);
    tick(1); chk("R2 up at k+2", up_flag, 1);
    chk("R9 mon shows ref at k+2", mon_out, 1);
    tick(1); chk("R2 ph_p low at k+3", ph_p_out, 0);
    chk("R2 lock_n low at k+3", lock_n, 0);
    fb_in = 1;
    tick(8);
    chk("R4 cleared", {up_flag, dn_flag}, 0);
    // R9: select feedback for monitor
    pol_sel = 0; fb_in = 0;
    tick(1); chk("R9 mon follows pol_sel in one edge", mon_out, 1);
    tick(2); chk("R9 mon shows fb low", mon_out, 0);
    pol_sel = 1;
    tick(1); chk("R9 mon back to ref", mon_out, 1);

    // R10: falling edges set nothing
    clr_cnt(); cnt_en = 1;
    ref_in = 0;
    tick(8);
    cnt_en = 0;
    chk("R10 no up after falling edge", c_up, 0);
    chk("R10 lock_n stays high", c_lockl, 0);

    // Full sweep of order, spacing, polarity and switch enable
    for (int fc = 0; fc < 2; fc++)
      for (int le = 0; le < 2; le++)
        for (int rf = 0; rf < 2; rf++)
          for (int d = 0; d < 8; d++)
            trial(rf, d, fc, le);

    // R3: repeated reference edges before feedback do not extend or restart
    pol_sel = 1; sw_en = 1;
    tick(4); clr_cnt(); cnt_en = 1;
    ref_in = 1; tick(2); ref_in = 0; tick(2); ref_in = 1; tick(2);
    fb_in = 1; tick(14);
    ref_in = 0; fb_in = 0; tick(6); cnt_en = 0;
    check_counts("R3 double ref", 1, 1, 6 + RD, RD, 6 + RD);

    // R3: feedback running faster, three edges before reference, pol_sel=0
    pol_sel = 0; sw_en = 0;
    tick(4); clr_cnt(); cnt_en = 1;
    for (int i = 0; i < 3; i++) begin
      fb_in = 1; tick(2); fb_in = 0; tick(2);
    end
    ref_in = 1; tick(14);
    ref_in = 0; tick(6); cnt_en = 0;
    check_counts("R3 fast fb", 0, 0, RD, 12 + RD, 12 + RD);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule